// File: doc/BRIEF.md
# Power Partition Gate Controller

This block switches supply power to seven on-chip partitions and controls the isolation clamp of each partition. Software talks to it over a plain 32-bit register bus with an address, a write strobe, write data and combinational read data. A write to the toggle register flips the requested power state of one partition. A write to the clamp-release register drops isolation on partitions that are fully powered. A read of the status register returns which partitions have finished powering up.

Each partition has its own settle window, which opens when a toggle is accepted. In the default build the window is a fixed count of `PGOOD_DLY` cycles. With `EXT_PGOOD` set, the window ends when that partition's `pgood_in` bit matches its requested state. A toggle that arrives while a partition is still settling is dropped. Turning a partition off re-arms its clamp on the same edge that drops its power enable.

The clamp-release bits for the video-decode partition (id 3) and the PCIe partition (id 4) are cross-wired. Release bit 3 acts on partition 4, and release bit 4 acts on partition 3. Every other release bit acts on the partition with the same index.

Top module: `pwr_part_gate_ctrl`

## Requirements
- R1: While `rst_n` is low on a clock edge, every `pwr_en` bit goes to 0, every `clamp_en` bit goes to 1, and the status register reads 0.
- R2: A write to address 0x30 with bit 8 set and a partition index 0..6 in bits [7:0] inverts that partition's `pwr_en` on the same edge. No other partition changes.
- R3: The following writes change nothing: a write to 0x30 with bit 8 clear, a write to 0x30 with an index of 7 or above, and a write with bit 8 set to any other address.
- R4: With the internal delay, the status bit of a toggled partition takes the new `pwr_en` value exactly `PGOOD_DLY` edges after the edge that accepted the toggle. In external mode it takes that value one edge after `pgood_in` matches `pwr_en`.
- R5: A toggle to a partition whose settle window is still open is ignored.
- R6: A write to 0x34 clears the clamp of each selected partition that is powered on and settled. The mapping is: bit k selects partition k for k other than 3 and 4, bit 3 selects partition 4, and bit 4 selects partition 3. Release bits for a partition that is unpowered or still settling are ignored.
- R7: An accepted power-off toggle sets that partition's `clamp_en` on the edge where its `pwr_en` falls. A partition with `pwr_en` at 0 always has `clamp_en` at 1.
- R8: A read of 0x38 returns the status in bits [6:0], indexed by partition id, with 1 meaning powered. Bits [31:7] read 0, and reads of 0x30 and 0x34 return 0.
- R9: Each partition has its own settle window, so a toggle to a partition that is not settling is accepted while another partition is settling.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Register byte address |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| pgood_in | input | 7 | Per-partition power-good, used only when `EXT_PGOOD` is 1 |
| pwr_en | output | 7 | Per-partition power switch enable |
| clamp_en | output | 7 | Per-partition isolation clamp enable, 1 means clamped |

## Verification
The bound checker watches four properties on every cycle:
- a power enable changes only after a qualifying toggle write, and never more than one bit per edge;
- an unpowered partition is never unclamped;
- a clamp drops only after a release write;
- a status bit only ever moves toward the partition's power enable, and the unused read bits stay zero.

Other behaviours depend on the history of writes, so only the bench's scenarios can show them:
- the exact settle delay;
- dropping a toggle while a partition is settling;
- the swapped release bits for partitions 3 and 4;
- ignoring a release aimed at a partition that is still powering up.

// File: rtl/pgate_pkg.sv
// Shared constants and the clamp-release bit mapping for the gate controller.
// Assumes a byte-addressed 32-bit register bus with an 8-bit address.
package pgate_pkg;
    localparam int PART_CNT   = 7;
    localparam int ADDR_W     = 8;
    localparam int DATA_W     = 32;
    localparam int TOG_GO_BIT = 8;
    localparam int TOG_IDX_W  = 8;
    localparam int ID_VDEC    = 3;
    localparam int ID_PCIE    = 4;

    localparam logic [ADDR_W-1:0] ADR_TOGGLE  = 8'h30;
    localparam logic [ADDR_W-1:0] ADR_RELEASE = 8'h34;
    localparam logic [ADDR_W-1:0] ADR_STATUS  = 8'h38;

    // Maps a clamp-release bit position to the partition whose clamp it drives.
    function automatic int release_target(input int bit_pos, input int nparts);
        if (nparts > ID_PCIE && bit_pos == ID_VDEC) return ID_PCIE;
        if (nparts > ID_PCIE && bit_pos == ID_PCIE) return ID_VDEC;
        return bit_pos;
    endfunction
endpackage

// File: rtl/pgate_regif.sv
// Register decode for the gate controller.
// Turns bus writes into one-hot per-partition toggle and release strobes and
// muxes the status register onto the read data.
// Assumes writes take effect on the clock edge where bus_we is high.
module pgate_regif
    import pgate_pkg::*;
#(
    parameter int NUM_PART = PART_CNT
) (
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_we,
    input  logic [DATA_W-1:0]   bus_wdata,
    input  logic [NUM_PART-1:0] part_powered,
    output logic [NUM_PART-1:0] tog_sel,
    output logic [NUM_PART-1:0] rel_sel,
    output logic [DATA_W-1:0]   bus_rdata
);
    logic                 tog_hit;
    logic                 rel_hit;
    logic [TOG_IDX_W-1:0] tog_idx;
    logic                 unused_wdata;

    assign tog_hit      = bus_we && (bus_addr == ADR_TOGGLE) && bus_wdata[TOG_GO_BIT];
    assign rel_hit      = bus_we && (bus_addr == ADR_RELEASE);
    assign tog_idx      = bus_wdata[TOG_IDX_W-1:0];
    assign unused_wdata = ^bus_wdata[DATA_W-1:TOG_GO_BIT+1];

    // Decode the toggle index; an out-of-range index selects nothing.
    always_comb begin
        for (int i = 0; i < NUM_PART; i++) begin
            tog_sel[i] = tog_hit && (tog_idx == TOG_IDX_W'(i));
        end
    end

    // Route release bits through the cross-wired mapping.
    always_comb begin
        rel_sel = '0;
        for (int k = 0; k < NUM_PART; k++) begin
            if (rel_hit && bus_wdata[k]) rel_sel[release_target(k, NUM_PART)] = 1'b1;
        end
    end

    // Read mux: only the status register returns data.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADR_STATUS) bus_rdata[NUM_PART-1:0] = part_powered;
    end
endmodule

// File: rtl/pgate_slice.sv
// Per-partition state: power enable, settle window, powered status and clamp.
// The settle window ends after a fixed cycle count or when external
// power-good matches the request, chosen by EXT_PGOOD.
// Assumes PGOOD_DLY >= 1.
module pgate_slice #(
    parameter int PGOOD_DLY = 4,
    parameter bit EXT_PGOOD = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tog_req,
    input  logic rel_req,
    input  logic pgood,
    output logic pwr_en,
    output logic clamp_en,
    output logic powered
);
    logic busy;
    logic accept;
    logic settle_done;

    assign accept = tog_req && !busy;

    // Flip the power request when a toggle is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n)      pwr_en <= 1'b0;
        else if (accept) pwr_en <= ~pwr_en;
    end

    // Hold the settle window open from an accepted toggle until it completes.
    always_ff @(posedge clk) begin
        if (!rst_n)           busy <= 1'b0;
        else if (accept)      busy <= 1'b1;
        else if (settle_done) busy <= 1'b0;
    end

    // Publish the settled power state.
    always_ff @(posedge clk) begin
        if (!rst_n)           powered <= 1'b0;
        else if (settle_done) powered <= pwr_en;
    end

    // Re-clamp on power-off, release only when powered and settled.
    always_ff @(posedge clk) begin
        if (!rst_n)                                     clamp_en <= 1'b1;
        else if (accept && pwr_en)                      clamp_en <= 1'b1;
        else if (rel_req && powered && pwr_en && !busy) clamp_en <= 1'b0;
    end

    generate
        if (EXT_PGOOD) begin : g_ext
            assign settle_done = busy && (pgood == pwr_en);
        end else begin : g_int
            localparam int CNT_W = $clog2(PGOOD_DLY + 1);
            logic [CNT_W-1:0] cnt;
            logic             unused_pgood;
            assign unused_pgood = pgood;
            assign settle_done  = busy && (cnt == CNT_W'(1));
            // Count down the fixed power-good delay.
            always_ff @(posedge clk) begin
                if (!rst_n)              cnt <= '0;
                else if (accept)         cnt <= CNT_W'(PGOOD_DLY);
                else if (cnt != '0)      cnt <= cnt - CNT_W'(1);
            end
        end
    endgenerate
endmodule

// File: rtl/pwr_part_gate_ctrl.sv
// Top of the power partition gate controller.
// Joins the register decode with one state slice per partition.
// Assumes a single clock domain and a synchronous active-low reset.
module pwr_part_gate_ctrl
    import pgate_pkg::*;
#(
    parameter int NUM_PART  = PART_CNT,
    parameter int PGOOD_DLY = 4,
    parameter bit EXT_PGOOD = 1'b0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_we,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [NUM_PART-1:0] pgood_in,
    output logic [NUM_PART-1:0] pwr_en,
    output logic [NUM_PART-1:0] clamp_en
);
    logic [NUM_PART-1:0] tog_sel;
    logic [NUM_PART-1:0] rel_sel;
    logic [NUM_PART-1:0] part_powered;

    pgate_regif #(.NUM_PART(NUM_PART)) u_regif (
        .bus_addr     (bus_addr),
        .bus_we       (bus_we),
        .bus_wdata    (bus_wdata),
        .part_powered (part_powered),
        .tog_sel      (tog_sel),
        .rel_sel      (rel_sel),
        .bus_rdata    (bus_rdata)
    );

    generate
        for (genvar p = 0; p < NUM_PART; p++) begin : g_part
            pgate_slice #(.PGOOD_DLY(PGOOD_DLY), .EXT_PGOOD(EXT_PGOOD)) u_slice (
                .clk      (clk),
                .rst_n    (rst_n),
                .tog_req  (tog_sel[p]),
                .rel_req  (rel_sel[p]),
                .pgood    (pgood_in[p]),
                .pwr_en   (pwr_en[p]),
                .clamp_en (clamp_en[p]),
                .powered  (part_powered[p])
            );
        end
    endgenerate
endmodule

// File: rtl/pgate_chk.sv
// Cycle-level checker for the gate controller, bound onto the top module.
// Assumes the address map of pgate_pkg.
module pgate_chk
    import pgate_pkg::*;
#(
    parameter int NUM_PART = PART_CNT
) (
    input logic                clk,
    input logic                rst_n,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic                bus_we,
    input logic [DATA_W-1:0]   bus_wdata,
    input logic [DATA_W-1:0]   bus_rdata,
    input logic [NUM_PART-1:0] pwr_en,
    input logic [NUM_PART-1:0] clamp_en,
    input logic [NUM_PART-1:0] st
);
    // R2: power enable moves only after a qualifying toggle write
    p_pwr_needs_toggle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_en != $past(pwr_en)) |->
            $past(bus_we && bus_addr == ADR_TOGGLE && bus_wdata[TOG_GO_BIT]));

    // R2: at most one partition changes per edge
    p_single_flip_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(pwr_en ^ $past(pwr_en)) <= 1);

    // R7: an unpowered partition is always clamped
    p_off_is_clamped_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((~pwr_en) & (~clamp_en)) == '0);

    // R6: a clamp drops only after a release write
    p_release_needs_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(clamp_en) & ~clamp_en) != '0) |->
            $past(bus_we && bus_addr == ADR_RELEASE));

    // R4: a status bit only changes toward its power enable
    p_status_tracks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((st ^ $past(st)) & (st ^ pwr_en)) == '0);

    // R8: unused read bits are zero
    p_rdata_upper_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[DATA_W-1:NUM_PART] == '0);
endmodule

bind pwr_part_gate_ctrl pgate_chk #(.NUM_PART(NUM_PART)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pwr_en    (pwr_en),
    .clamp_en  (clamp_en),
    .st        (part_powered)
);

// File: tb/tb_pwr_part_gate_ctrl.sv
module tb_pwr_part_gate_ctrl;
    localparam int NP  = 7;
    localparam int DLY = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NP-1:0] pgood_in = '0;
    logic [NP-1:0] pwr_en;
    logic [NP-1:0] clamp_en;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pwr_part_gate_ctrl #(.NUM_PART(NP), .PGOOD_DLY(DLY), .EXT_PGOOD(1'b0)) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pgood_in(pgood_in),
        .pwr_en(pwr_en), .clamp_en(clamp_en)
    );

    typedef struct packed {
        logic [7:0]  addr;
        logic [31:0] data;
        logic [6:0]  pwr;
        logic [6:0]  clamp;
        logic [6:0]  stat;
        logic [7:0]  req;
    } vec_t;

    // One write per row, then the settled outputs it should produce.
    localparam vec_t VECS [12] = '{
        '{8'h30, 32'h0000_0100, 7'h01, 7'h7F, 7'h01, 8'd2}, // R2 cpu on
        '{8'h30, 32'h0000_0103, 7'h09, 7'h7F, 7'h09, 8'd2}, // R2 vdec on
        '{8'h30, 32'h0000_0104, 7'h19, 7'h7F, 7'h19, 8'd2}, // R2 pcie on
        '{8'h34, 32'h0000_0008, 7'h19, 7'h6F, 7'h19, 8'd6}, // R6 bit3 -> pcie
        '{8'h34, 32'h0000_0010, 7'h19, 7'h67, 7'h19, 8'd6}, // R6 bit4 -> vdec
        '{8'h30, 32'h0000_0003, 7'h19, 7'h67, 7'h19, 8'd3}, // R3 go bit clear
        '{8'h30, 32'h0000_0107, 7'h19, 7'h67, 7'h19, 8'd3}, // R3 index 7
        '{8'h34, 32'h0000_0002, 7'h19, 7'h67, 7'h19, 8'd6}, // R6 unpowered 3d
        '{8'h34, 32'h0000_0001, 7'h19, 7'h66, 7'h19, 8'd6}, // R6 cpu released
        '{8'h30, 32'h0000_0104, 7'h09, 7'h76, 7'h09, 8'd7}, // R7 pcie off
        '{8'h38, 32'h0000_0102, 7'h09, 7'h76, 7'h09, 8'd3}, // R3 wrong address
        '{8'h30, 32'h0000_0106, 7'h49, 7'h76, 7'h49, 8'd8}  // R8 mpe in bit 6
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(4 * 20000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        // R1 reset state, R8 zero reads
        check("R1 pwr", 32'(pwr_en), 32'h0);
        check("R1 clamp", 32'(clamp_en), 32'h7F);
        rd(8'h38, r); check("R1 status", r, 32'h0);
        rd(8'h30, r); check("R8 toggle reads 0", r, 32'h0);
        rd(8'h34, r); check("R8 release reads 0", r, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < 12; i++) begin
            wr(VECS[i].addr, VECS[i].data);
            repeat (6) @(negedge clk);
            check($sformatf("R%0d row %0d pwr", VECS[i].req, i), 32'(pwr_en), 32'(VECS[i].pwr));
            check($sformatf("R%0d row %0d clamp", VECS[i].req, i), 32'(clamp_en), 32'(VECS[i].clamp));
            rd(8'h38, r);
            check($sformatf("R%0d row %0d status", VECS[i].req, i), r, 32'(VECS[i].stat));
        end

        // R4, R5, R9: settle timing, busy drop, independent partition
        bus_addr = 8'h30; bus_wdata = 32'h105; bus_we = 1'b1;
        @(posedge clk); @(negedge clk);                  // n0
        check("R2 p5 on next edge", 32'(pwr_en[5]), 32'h1);
        bus_wdata = 32'h105;                             // R5 retoggle while busy
        @(posedge clk); @(negedge clk);                  // n1
        check("R5 busy toggle ignored", 32'(pwr_en[5]), 32'h1);
        bus_wdata = 32'h102;                             // R9 other partition
        @(posedge clk); @(negedge clk);                  // n2
        bus_we = 1'b0; bus_wdata = '0;
        check("R9 p2 accepted", 32'(pwr_en[2]), 32'h1);
        @(posedge clk); @(negedge clk);                  // n3
        rd(8'h38, r); check("R4 status not before delay", 32'(r[5]), 32'h0);
        @(posedge clk); @(negedge clk);                  // n4
        rd(8'h38, r); check("R4 status at delay", 32'(r[5]), 32'h1);
        repeat (8) @(negedge clk);
        rd(8'h38, r); check("R9 status both", r, 32'h6D);

        // R6: release during power-up window is ignored
        wr(8'h30, 32'h101);
        wr(8'h34, 32'h2);
        repeat (6) @(negedge clk);
        check("R6 release while settling ignored", 32'(clamp_en[1]), 32'h1);
        wr(8'h34, 32'h2);
        check("R6 release after settle", 32'(clamp_en), 32'h74);

        // R7: power-off re-clamps on the same edge
        wr(8'h30, 32'h100);
        check("R7 pwr off", 32'(pwr_en[0]), 32'h0);
        check("R7 clamp set", 32'(clamp_en[0]), 32'h1);
        repeat (6) @(negedge clk);

        // R1: reset mid-operation
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 pwr after reset", 32'(pwr_en), 32'h0);
        check("R1 clamp after reset", 32'(clamp_en), 32'h7F);
        rd(8'h38, r); check("R1 status after reset", r, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        finish_run();
    end
endmodule